// File: doc/BRIEF.md
# Serial port control and status register bank

This block is the register bank of an asynchronous serial port that has a receive FIFO. A host reaches it through a plain single-cycle register port addressed by byte offset. It holds the mode, bit-rate, control, FIFO-control and port settings. It keeps five line flags and packs them into one status word. It drives a transmit interrupt level and a receive interrupt level. The serializer, the baud generator and the receive FIFO are separate blocks. The serializer reads `mode_o` and `rate_o`. The FIFO reports its fill count and its event pulses to this bank. It also takes pop, clear and trigger-level signals back from it.

Flags are cleared by writing zero to their bit in the status word; writing one leaves a flag alone. A status read made while the transmitter is enabled returns the flags as they stood, and then sets transmit-empty and transmit-end again. Writing the transmit data offset sends the byte out on `tx_valid`/`tx_data` as a one-cycle strobe. This output has no ready: the serializer must take the byte in the cycle it is offered, and there is no back-pressure. `rx_pop` and `rx_clr` are one-cycle strobes in the same way.

Top module: `sercfg_regs`

## Requirements
- R1: After reset, reads give mode 0x00, bit rate 0xFF, control 0x20, port 0x00, FIFO control 0x0000, and status 0x0060. `tx_irq`, `rx_irq`, `tx_valid`, `rx_pop` and `rx_clr` are 0.
- R2: A request takes one cycle, and read data appears on `rd_data` in the cycle after the request. Offsets are: mode 0x00, bit rate 0x04, control 0x08, FIFO control 0x18 and port 0x20. The stored value is masked by 0x7B for mode, 0xFA for control and 0xF3 for port. Bit rate keeps all 8 bits and FIFO control keeps all 16 bits.
- R3: The status word at 0x10 has transmit end at bit 6, transmit empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0. All other bits read 0. A status write clears each of these flags whose bit is 0 and keeps each flag whose bit is 1.
- R4: A status read while control bit 5 is 1 returns the flags as they were, then sets transmit end and transmit empty. With control bit 5 at 0, a status read changes no flag.
- R5: A control write with bit 5 at 0 sets transmit end. `tx_irq` equals the stored control bit 7.
- R6: A write to 0x0C gives exactly one cycle of `tx_valid`, in the cycle after the write, with `tx_data` set to the low byte. It also clears transmit empty.
- R7: `rx_irq` is set when `evt_rxf` pulses while control bit 6 is 1. It is cleared by a control write with bit 6 at 0, or by a status write with bit 1 or bit 0 at 0.
- R8: A read of 0x14 with `rx_count` > 0 returns `rx_data` and pulses `rx_pop` for one cycle. With `rx_count` = 0 it returns 0 and gives no pop. A read of 0x1C returns `rx_count`.
- R9: `rx_trig` follows FIFO control bits 7:6: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives FIFO_DEPTH-2. A FIFO-control write with bit 1 at 1 pulses `rx_clr` for one cycle.
- R10: The offsets 0x0C and 0x24, and every offset not listed here, read 0. Writes to 0x14, 0x1C, 0x24 and the unlisted offsets change no register, flag or output.
- R11: The event inputs `evt_brk`, `evt_rxf` and `evt_dr` set break, receive full and data ready. An event beats a status-write clear of the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | BUS_W | Write data |
| rd_data | output | BUS_W | Registered read data |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |
| evt_brk | input | 1 | Break detected pulse |
| evt_rxf | input | 1 | FIFO reached trigger pulse |
| evt_dr | input | 1 | Data ready pulse |
| rx_count | input | CNT_W | FIFO fill count |
| rx_data | input | 8 | FIFO head byte |
| rx_pop | output | 1 | Pop FIFO head |
| rx_clr | output | 1 | Clear FIFO |
| rx_trig | output | CNT_W | Receive trigger level |
| mode_o | output | 8 | Stored mode |
| rate_o | output | 8 | Stored bit rate |

## Verification
The hardest case to reach is the write-zero clear under every pattern. Each of the five flags must be set before each status write, and two of them can only be set again through the re-arming status read. The stimulus covers this with a loop over all 256 write values. Each pass pulses all three events, does a re-arming read with control bits 5 and 6 set, writes the pattern, then reads the status back and samples `rx_irq`. A same-cycle event and clear is driven on purpose, because the host side alone can never make it happen.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTRL_MASK = 8'hFA;
  localparam logic [7:0] PORT_MASK = 8'hF3;
  localparam logic [7:0] RATE_RST  = 8'hFF;
  localparam logic [7:0] CTRL_RST  = 8'h20;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_RATE, SEL_CTRL, SEL_TDR, SEL_STAT,
    SEL_RDR, SEL_FCR, SEL_CNT, SEL_PORT, SEL_LINE, SEL_NONE
  } sel_e;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rxf;
    logic dr;
  } flags_t;

  function automatic sel_e decode(input logic [31:0] offs);
    case (offs)
      32'h00: decode = SEL_MODE;
      32'h04: decode = SEL_RATE;
      32'h08: decode = SEL_CTRL;
      32'h0C: decode = SEL_TDR;
      32'h10: decode = SEL_STAT;
      32'h14: decode = SEL_RDR;
      32'h18: decode = SEL_FCR;
      32'h1C: decode = SEL_CNT;
      32'h20: decode = SEL_PORT;
      32'h24: decode = SEL_LINE;
      default: decode = SEL_NONE;
    endcase
  endfunction

  function automatic logic [15:0] pack_status(input flags_t f);
    pack_status = {9'b0, f.tend, f.tde, f.brk, 2'b00, f.rxf, f.dr};
  endfunction
endpackage

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  sel_e             sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [7:0]       mode_q,
  output logic [7:0]       rate_q,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       port_q,
  output logic [BUS_W-1:0] fcr_q,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             rx_clr,
  output logic [CNT_W-1:0] rx_trig
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      rate_q   <= RATE_RST;
      ctrl_q   <= CTRL_RST;
      port_q   <= '0;
      fcr_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      rx_clr   <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      rx_clr   <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_MODE: mode_q <= wdata[7:0] & MODE_MASK;
          SEL_RATE: rate_q <= wdata[7:0];
          SEL_CTRL: ctrl_q <= wdata[7:0] & CTRL_MASK;
          SEL_PORT: port_q <= wdata[7:0] & PORT_MASK;
          SEL_TDR: begin
            tx_valid <= 1'b1;
            tx_data  <= wdata[7:0];
          end
          SEL_FCR: begin
            fcr_q  <= wdata;
            rx_clr <= wdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (fcr_q[7:6])
      2'd0:    rx_trig = CNT_W'(1);
      2'd1:    rx_trig = CNT_W'(4);
      2'd2:    rx_trig = CNT_W'(8);
      default: rx_trig = CNT_W'(FIFO_DEPTH - 2);
    endcase
  end
endmodule

// File: rtl/sercfg_flags.sv
module sercfg_flags
  import sercfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_stat,
  input  logic   wr_ctrl,
  input  logic   wr_tdr,
  input  logic   rd_stat,
  input  flags_t keep,
  input  logic   ctrl_w_te,
  input  logic   ctrl_w_rie,
  input  logic   te_q,
  input  logic   rie_q,
  input  logic   evt_brk,
  input  logic   evt_rxf,
  input  logic   evt_dr,
  output flags_t flags_q,
  output logic   rx_irq
);
  flags_t nxt;
  logic   irq_nxt;

  always_comb begin
    nxt = flags_q;
    if (wr_stat) nxt = flags_q & keep;
    if (wr_ctrl && !ctrl_w_te) nxt.tend = 1'b1;
    if (wr_tdr) nxt.tde = 1'b0;
    if (rd_stat && te_q) begin
      nxt.tde  = 1'b1;
      nxt.tend = 1'b1;
    end
    if (evt_brk) nxt.brk = 1'b1;
    if (evt_rxf) nxt.rxf = 1'b1;
    if (evt_dr)  nxt.dr  = 1'b1;

    irq_nxt = rx_irq;
    if ((wr_ctrl && !ctrl_w_rie) || (wr_stat && !(keep.rxf && keep.dr)))
      irq_nxt = 1'b0;
    if (evt_rxf && rie_q) irq_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rxf: 1'b0, dr: 1'b0};
      rx_irq  <= 1'b0;
    end else begin
      flags_q <= nxt;
      rx_irq  <= irq_nxt;
    end
  end
endmodule

// File: rtl/sercfg_rdmux.sv
module sercfg_rdmux
  import sercfg_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  sel_e             sel,
  input  logic [7:0]       mode_q,
  input  logic [7:0]       rate_q,
  input  logic [7:0]       ctrl_q,
  input  logic [7:0]       port_q,
  input  logic [BUS_W-1:0] fcr_q,
  input  flags_t           flags_q,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [7:0]       rx_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             rx_pop
);
  logic [BUS_W-1:0] val;
  logic             pop_nxt;

  always_comb begin
    val     = '0;
    pop_nxt = 1'b0;
    case (sel)
      SEL_MODE: val = BUS_W'(mode_q);
      SEL_RATE: val = BUS_W'(rate_q);
      SEL_CTRL: val = BUS_W'(ctrl_q);
      SEL_PORT: val = BUS_W'(port_q);
      SEL_FCR:  val = fcr_q;
      SEL_STAT: val = BUS_W'(pack_status(flags_q));
      SEL_CNT:  val = BUS_W'(rx_count);
      SEL_RDR: begin
        if (rx_count != '0) begin
          val     = BUS_W'(rx_data);
          pop_nxt = 1'b1;
        end
      end
      default: val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rx_pop  <= 1'b0;
    end else begin
      rx_pop <= rd && pop_nxt;
      if (rd) rd_data <= val;
    end
  end
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic [BUS_W-1:0]  rd_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              evt_brk,
  input  logic              evt_rxf,
  input  logic              evt_dr,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic              rx_clr,
  output logic [CNT_W-1:0]  rx_trig,
  output logic [7:0]        mode_o,
  output logic [7:0]        rate_o
);
  sel_e             sel;
  logic             wr_req, rd_req;
  logic [7:0]       ctrl_q, port_q;
  logic [BUS_W-1:0] fcr_q;
  flags_t           flags_q, keep;

  assign sel    = decode(32'(req_addr));
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign keep   = '{tend: req_wdata[6], tde: req_wdata[5], brk: req_wdata[4],
                    rxf: req_wdata[1], dr: req_wdata[0]};
  assign tx_irq = ctrl_q[7];

  sercfg_ctrl #(.BUS_W(BUS_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_req), .sel(sel), .wdata(req_wdata),
    .mode_q(mode_o), .rate_q(rate_o), .ctrl_q(ctrl_q), .port_q(port_q),
    .fcr_q(fcr_q), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_clr(rx_clr), .rx_trig(rx_trig)
  );

  sercfg_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(wr_req && sel == SEL_STAT),
    .wr_ctrl(wr_req && sel == SEL_CTRL),
    .wr_tdr(wr_req && sel == SEL_TDR),
    .rd_stat(rd_req && sel == SEL_STAT),
    .keep(keep), .ctrl_w_te(req_wdata[5]), .ctrl_w_rie(req_wdata[6]),
    .te_q(ctrl_q[5]), .rie_q(ctrl_q[6]),
    .evt_brk(evt_brk), .evt_rxf(evt_rxf), .evt_dr(evt_dr),
    .flags_q(flags_q), .rx_irq(rx_irq)
  );

  sercfg_rdmux #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd(rd_req), .sel(sel),
    .mode_q(mode_o), .rate_q(rate_o), .ctrl_q(ctrl_q), .port_q(port_q),
    .fcr_q(fcr_q), .flags_q(flags_q), .rx_count(rx_count), .rx_data(rx_data),
    .rd_data(rd_data), .rx_pop(rx_pop)
  );
endmodule

// File: rtl/sercfg_regs_chk.sv
module sercfg_regs_chk
  import sercfg_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd,
  input logic             wr,
  input sel_e             sel,
  input logic [BUS_W-1:0] wdata,
  input logic [BUS_W-1:0] rd_data,
  input logic             tx_valid,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             evt_rxf,
  input logic             te,
  input flags_t           flags
);
  AST_TX_STROBE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_TDR) |=> tx_valid); // R6
  AST_TX_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_TDR) |=> !tx_valid); // R6
  AST_TDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_TDR) |=> !flags.tde); // R6
  AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_STAT) |=> ((rd_data & 16'hFF8C) == '0)); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (sel == SEL_NONE || sel == SEL_LINE || sel == SEL_TDR)) |=> (rd_data == '0)); // R10
  AST_TXIRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL) |=> (tx_irq == $past(wdata[7]))); // R5
  AST_TEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL && !wdata[5]) |=> flags.tend); // R5
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_STAT && te) |=> (flags.tde && flags.tend)); // R4
  AST_RXIRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL && !wdata[6] && !evt_rxf) |=> !rx_irq); // R7
endmodule

bind sercfg_regs sercfg_regs_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd_req), .wr(wr_req), .sel(sel),
  .wdata(req_wdata), .rd_data(rd_data), .tx_valid(tx_valid), .tx_irq(tx_irq),
  .rx_irq(rx_irq), .evt_rxf(evt_rxf), .te(ctrl_q[5]), .flags(flags_q)
);

// File: tb/sercfg_regs_tb.sv
module sercfg_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rd_data;
  logic        tx_valid, tx_irq, rx_irq, rx_pop, rx_clr;
  logic [7:0]  tx_data, mode_o, rate_o;
  logic        evt_brk = 1'b0, evt_rxf = 1'b0, evt_dr = 1'b0;
  logic [4:0]  rx_count = '0;
  logic [7:0]  rx_data = '0;
  logic [4:0]  rx_trig;

  int total = 0, fails = 0, tx_seen = 0, tx_writes = 0;
  logic [15:0] v;

  always #10 clk = ~clk;

  sercfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .evt_brk(evt_brk), .evt_rxf(evt_rxf), .evt_dr(evt_dr),
    .rx_count(rx_count), .rx_data(rx_data), .rx_pop(rx_pop), .rx_clr(rx_clr),
    .rx_trig(rx_trig), .mode_o(mode_o), .rate_o(rate_o)
  );

  always @(negedge clk) if (rst_n && tx_valid) tx_seen++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    if (a == 6'h0C) tx_writes++;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic b, input logic r, input logic d);
    @(negedge clk);
    evt_brk = b; evt_rxf = r; evt_dr = d;
    @(negedge clk);
    evt_brk = 1'b0; evt_rxf = 1'b0; evt_dr = 1'b0;
  endtask

  function automatic bit readable(input int a);
    return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h10 || a == 'h14 ||
           a == 'h18 || a == 'h1C || a == 'h20;
  endfunction

  function automatic bit writable(input int a);
    return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h0C || a == 'h10 ||
           a == 'h18 || a == 'h20;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 tx_irq", {15'b0, tx_irq}, 16'h0);
    chk("R1 rx_irq", {15'b0, rx_irq}, 16'h0);
    chk("R1 tx_valid", {15'b0, tx_valid}, 16'h0);
    chk("R1 rx_clr", {15'b0, rx_clr}, 16'h0);
    chk("R9 reset trig", {11'b0, rx_trig}, 16'd1);
    rd(6'h00, v); chk("R1 mode", v, 16'h0000);
    rd(6'h04, v); chk("R1 rate", v, 16'h00FF);
    rd(6'h08, v); chk("R1 ctrl", v, 16'h0020);
    rd(6'h20, v); chk("R1 port", v, 16'h0000);
    rd(6'h18, v); chk("R1 fcr", v, 16'h0000);
    rd(6'h10, v); chk("R1 status", v, 16'h0060);

    // R2 mask sweeps
    for (int i = 0; i < 256; i++) begin
      wr(6'h00, 16'(i)); rd(6'h00, v); chk("R2 mode mask", v, 16'(i & 'h7B));
      chk("R2 mode_o", {8'b0, mode_o}, 16'(i & 'h7B));
      wr(6'h04, 16'(i)); rd(6'h04, v); chk("R2 rate", v, 16'(i));
      wr(6'h20, 16'(i)); rd(6'h20, v); chk("R2 port mask", v, 16'(i & 'hF3));
    end
    wr(6'h18, 16'hA5C3); rd(6'h18, v); chk("R2 fcr 16 bit", v, 16'hA5C3);

    // R5 control sweep: tend set on bit5 clear, tx_irq level
    for (int i = 0; i < 256; i++) begin
      wr(6'h10, 16'h0000);
      wr(6'h08, 16'(i));
      chk("R5 tx_irq", {15'b0, tx_irq}, 16'(i >> 7));
      rd(6'h08, v); chk("R2 ctrl mask", v, 16'(i & 'hFA));
      rd(6'h10, v); chk("R5 tend after ctrl", v, ((i & 'h20) != 0) ? 16'h0000 : 16'h0040);
    end

    // R3 and R7 status write sweep with all flags set first
    wr(6'h08, 16'h0060);
    for (int i = 0; i < 256; i++) begin
      pulse(1'b1, 1'b1, 1'b1);
      rd(6'h10, v);
      chk("R7 rx_irq set", {15'b0, rx_irq}, 16'h1);
      wr(6'h10, 16'(i));
      chk("R7 rx_irq after stat", {15'b0, rx_irq}, ((i & 3) == 3) ? 16'h1 : 16'h0);
      rd(6'h10, v); chk("R3 status keep/clear", v, 16'(i & 'h73));
    end

    // R7 control clear, no set without enable
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 irq before ctrl clear", {15'b0, rx_irq}, 16'h1);
    wr(6'h08, 16'h0020);
    chk("R7 ctrl bit6 clear", {15'b0, rx_irq}, 16'h0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 no irq when disabled", {15'b0, rx_irq}, 16'h0);

    // R11 event beats same-cycle clear
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h10; req_wdata = 16'h0000; evt_dr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt_dr = 1'b0;
    wr(6'h08, 16'h0000);
    wr(6'h10, 16'h0001);
    rd(6'h10, v); chk("R11 event wins", v, 16'h0001);

    // R4 no re-arm with transmitter off, re-arm with it on
    wr(6'h10, 16'h0000);
    rd(6'h10, v); chk("R4 off read", v, 16'h0000);
    rd(6'h10, v); chk("R4 off no rearm", v, 16'h0000);
    wr(6'h08, 16'h0020);
    rd(6'h10, v); chk("R4 old value", v, 16'h0000);
    rd(6'h10, v); chk("R4 rearmed", v, 16'h0060);

    // R6 transmit strobe
    wr(6'h0C, 16'h12A5);
    chk("R6 tx_valid", {15'b0, tx_valid}, 16'h1);
    chk("R6 tx_data", {8'b0, tx_data}, 16'h00A5);
    @(negedge clk);
    chk("R6 single pulse", {15'b0, tx_valid}, 16'h0);
    wr(6'h08, 16'h0000);
    rd(6'h10, v); chk("R6 tde cleared", v, 16'h0040);
    wr(6'h0C, 16'h003C);
    wr(6'h0C, 16'h00C3);
    chk("R6 last byte", {8'b0, tx_data}, 16'h00C3);

    // R8 receive data and count
    rx_count = 5'd3; rx_data = 8'h5C;
    rd(6'h14, v); chk("R8 rx data", v, 16'h005C);
    chk("R8 pop", {15'b0, rx_pop}, 16'h1);
    @(negedge clk);
    chk("R8 pop one cycle", {15'b0, rx_pop}, 16'h0);
    rd(6'h1C, v); chk("R8 count", v, 16'h0003);
    rx_count = 5'd0;
    rd(6'h14, v); chk("R8 empty read", v, 16'h0000);
    chk("R8 no pop when empty", {15'b0, rx_pop}, 16'h0);

    // R9 trigger decode and clear strobe
    for (int c = 0; c < 4; c++) begin
      wr(6'h18, 16'(c << 6));
      chk("R9 trig", {11'b0, rx_trig}, (c == 0) ? 16'd1 : (c == 1) ? 16'd4 : (c == 2) ? 16'd8 : 16'd14);
      chk("R9 no clr", {15'b0, rx_clr}, 16'h0);
    end
    wr(6'h18, 16'h0002);
    chk("R9 clr pulse", {15'b0, rx_clr}, 16'h1);
    @(negedge clk);
    chk("R9 clr one cycle", {15'b0, rx_clr}, 16'h0);

    // R10 unmapped reads and ignored writes
    wr(6'h00, 16'h0011); wr(6'h04, 16'h0022); wr(6'h20, 16'h0033);
    wr(6'h18, 16'h0040); wr(6'h08, 16'h0000); wr(6'h10, 16'h0000);
    rx_count = 5'd2; rx_data = 8'h77;
    for (int a = 0; a < 64; a++)
      if (!readable(a)) begin rd(6'(a), v); chk("R10 unmapped read", v, 16'h0000); end
    for (int a = 0; a < 64; a++)
      if (!writable(a)) wr(6'(a), 16'hFFFF);
    chk("R10 no strobe", {14'b0, rx_pop, tx_irq}, 16'h0);
    rd(6'h00, v); chk("R10 mode kept", v, 16'h0011);
    rd(6'h04, v); chk("R10 rate kept", v, 16'h0022);
    rd(6'h20, v); chk("R10 port kept", v, 16'h0033);
    rd(6'h18, v); chk("R10 fcr kept", v, 16'h0040);
    rd(6'h08, v); chk("R10 ctrl kept", v, 16'h0000);
    rd(6'h10, v); chk("R10 status kept", v, 16'h0000);
    chk("R10 irq kept", {14'b0, rx_irq, tx_irq}, 16'h0);
    chk("R6 strobe count", 16'(tx_seen), 16'(tx_writes));

    summary();
    $finish;
  end
endmodule